// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Master

This block is a serial master for a link with one clock, one active-low chip select and a single data wire that both sides share. A transaction is started by a one-cycle strobe. The strobe carries two counts, each equal to the number of bits minus one. The engine drives the write bits onto the shared wire, most significant bit first. It then releases the wire during a short turnaround with the clock low, and clocks in the read bits. After the last read bit it holds the clock low and watches the same wire. When the target pulls the wire high, the engine raises a one-cycle interrupt and goes idle.

Transmit words come in on a 32-bit ready/valid stream and are consumed one per 32 written bits. Received bits are packed most significant bit first into 32-bit words and leave on a ready/valid stream. The last word of every read phase is the target's status word. A command-write moves N words with a write count of 32·N−1 and a read count of 31. A command-read sends one command word with a write count of 31 and reads M data words plus the status word with a read count of 32·M+31. Either stream can stall the engine, and no bit is lost. The engine advances one step per clock; clock division is done outside.

Top module: `hd3w_spi_engine`

## Requirements
- R1: Out of reset and whenever idle: `cs_n`=1, `sclk`=0, `dio_oe`=0, `dio_out`=0, `busy`=0, `irq`=0, `tx_ready`=0, `rx_valid`=0.
- R2: The write phase drives `wr_cnt`+1 bits, MSB of each word first, with `dio_oe`=1. Each bit takes two cycles: the bit is shown with `sclk`=0, then held for one cycle with `sclk`=1.
- R3: With `fast_mode`=0 (latched at start), the turnaround between the phases is two cycles with `sclk`=0 and `dio_oe`=0.
- R4: With `fast_mode`=1, the turnaround is three cycles with `dio_oe`=0 and `sclk` going low, high, low.
- R5: The read phase takes `rd_cnt`+1 bits. `sclk`=1 on the cycle whose closing edge samples `dio_in`, and `sclk`=0 on the next cycle. Every 32 bits form one word, first bit in bit 31. The word is offered with `rx_valid`=1 in the clock-low cycle that follows its last bit.
- R6: After the read phase the engine keeps `sclk`=0 and `cs_n`=0 until it samples `dio_in`=1. `irq` is then high for exactly one cycle, in the first cycle the engine is idle again.
- R7: `cs_n` is 0 from the cycle after an accepted start until the engine returns to idle.
- R8: A `start` strobe while `busy`=1 has no effect on the running transaction and starts no new one.
- R9: If no transmit word is offered when one is needed, the engine holds `sclk`=0 with `tx_ready`=1 and resumes with the same bit once `tx_valid` rises.
- R10: While `rx_valid`=1 and `rx_ready`=0, the engine takes no further bits and `rx_data` stays stable.
- R11: `tx_ready` is 1 only in the clock-low cycle of the first bit of each transmit word. A word is taken in that cycle when `tx_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transaction start strobe |
| wr_cnt | input | CNT_W | Write bits minus one |
| rd_cnt | input | CNT_W | Read bits minus one |
| fast_mode | input | 1 | Insert the extra turnaround clock pulse |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Engine takes the transmit word |
| rx_data | output | 32 | Received word |
| rx_valid | output | 1 | Received word valid |
| rx_ready | input | 1 | Consumer takes the received word |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| dio_out | output | 1 | Data value driven onto the shared wire |
| dio_oe | output | 1 | Output enable for the shared wire |
| dio_in | input | 1 | Data value read from the shared wire |
| busy | output | 1 | Transaction in progress |
| irq | output | 1 | One-cycle target event pulse |

## Verification
The bench targets the first bit of each transmit word. A shifter that refilled one cycle late would drive the previous word's leftover bit, or add a stall cycle that breaks the two-cycle bit rhythm. Both turnaround lengths are checked: a missing or extra pulse in fast mode shifts every read bit and corrupts the status word. Both streams are stalled in the middle of a transaction, where a wrong design would keep clocking and drop or overwrite bits. A start strobe is sent during the event wait, and the event is raised at once or after a delay, to catch an engine that restarts early or pulses `irq` for more than one cycle.

// File: rtl/hd3w_pkg.sv
package hd3w_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_TA_A,
        ST_TA_P,
        ST_TA_B,
        ST_RD_HI,
        ST_RD_LO,
        ST_WAIT
    } state_t;

    function automatic logic clk_high(input state_t s);
        return (s == ST_WR_HI) || (s == ST_TA_P) || (s == ST_RD_HI);
    endfunction

    function automatic logic drives_line(input state_t s);
        return (s == ST_WR_LO) || (s == ST_WR_HI);
    endfunction

endpackage

// File: rtl/hd3w_tx_shift.sv
module hd3w_tx_shift
    import hd3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              ld_phase,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              avail,
    output logic              bit_out
);
    logic [WORD_W-1:0] sreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              have_q;

    assign tx_ready = ld_phase && !have_q;
    assign avail    = have_q || tx_valid;
    assign bit_out  = have_q ? sreg_q[WORD_W-1] : tx_data[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            have_q <= 1'b0;
            idx_q  <= '0;
        end else if (tx_ready && tx_valid) begin
            sreg_q <= tx_data;
            have_q <= 1'b1;
        end else if (shift_en) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
            idx_q  <= idx_q + 1'b1;
            if (idx_q == IDX_W'(WORD_W - 1)) have_q <= 1'b0;
        end
    end
endmodule

// File: rtl/hd3w_rx_shift.sv
module hd3w_rx_shift
    import hd3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              sample,
    input  logic              din,
    input  logic              rx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              blocked
);
    logic [WORD_W-1:0] sreg_q;
    logic [IDX_W-1:0]  idx_q;

    assign blocked = rx_valid && !rx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            idx_q    <= '0;
        end else begin
            if (restart) idx_q <= '0;
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (sample) begin
                sreg_q <= {sreg_q[WORD_W-2:0], din};
                idx_q  <= idx_q + 1'b1;
                if (idx_q == IDX_W'(WORD_W - 1)) begin
                    rx_data  <= {sreg_q[WORD_W-2:0], din};
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hd3w_spi_engine.sv
module hd3w_spi_engine
    import hd3w_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [CNT_W-1:0] rd_cnt,
    input  logic             fast_mode,
    input  logic [31:0]      tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [31:0]      rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             cs_n,
    output logic             sclk,
    output logic             dio_out,
    output logic             dio_oe,
    input  logic             dio_in,
    output logic             busy,
    output logic             irq
);
    state_t           st_q, st_d;
    logic [CNT_W-1:0] wr_rem_q, rd_rem_q;
    logic             fast_q;
    logic             launch;
    logic             tx_avail, tx_bit, rx_block;

    assign launch = (st_q == ST_IDLE) && start;

    hd3w_tx_shift u_tx (
        .clk      (clk),
        .rst      (rst),
        .restart  (launch),
        .ld_phase (st_q == ST_WR_LO),
        .shift_en (st_q == ST_WR_HI),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .avail    (tx_avail),
        .bit_out  (tx_bit)
    );

    hd3w_rx_shift u_rx (
        .clk      (clk),
        .rst      (rst),
        .restart  (launch),
        .sample   (st_q == ST_RD_HI),
        .din      (dio_in),
        .rx_ready (rx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .blocked  (rx_block)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_WR_LO;
            ST_WR_LO: if (tx_avail) st_d = ST_WR_HI;
            ST_WR_HI: st_d = (wr_rem_q == '0) ? ST_TA_A : ST_WR_LO;
            ST_TA_A:  st_d = fast_q ? ST_TA_P : ST_TA_B;
            ST_TA_P:  st_d = ST_TA_B;
            ST_TA_B:  st_d = ST_RD_HI;
            ST_RD_HI: st_d = ST_RD_LO;
            ST_RD_LO: if (!rx_block) st_d = (rd_rem_q == '0) ? ST_WAIT : ST_RD_HI;
            ST_WAIT:  if (dio_in) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            wr_rem_q <= '0;
            rd_rem_q <= '0;
            fast_q   <= 1'b0;
            irq      <= 1'b0;
        end else begin
            st_q <= st_d;
            irq  <= (st_q == ST_WAIT) && dio_in;
            if (launch) begin
                wr_rem_q <= wr_cnt;
                rd_rem_q <= rd_cnt;
                fast_q   <= fast_mode;
            end
            if (st_q == ST_WR_HI && wr_rem_q != '0) wr_rem_q <= wr_rem_q - 1'b1;
            if (st_q == ST_RD_LO && !rx_block && rd_rem_q != '0) rd_rem_q <= rd_rem_q - 1'b1;
        end
    end

    assign busy    = (st_q != ST_IDLE);
    assign cs_n    = !busy;
    assign sclk    = clk_high(st_q);
    assign dio_oe  = drives_line(st_q);
    assign dio_out = dio_oe && tx_bit;
endmodule

// File: rtl/hd3w_checker.sv
module hd3w_checker (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        sclk,
    input logic        dio_oe,
    input logic        dio_out,
    input logic        dio_in,
    input logic        irq,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic [31:0] rx_data
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sclk && !dio_oe && !dio_out));

    assert_drive_selected_R7: assert property (@(posedge clk) disable iff (rst)
        dio_oe |-> !cs_n);

    assert_read_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (sclk && !dio_oe) |=> !sclk);

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_idle_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> cs_n);

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(dio_in));

    assert_tx_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && dio_oe && !sclk && tx_ready && !tx_valid) |=> (!sclk && dio_oe));

    assert_rx_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind hd3w_spi_engine hd3w_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .dio_oe   (dio_oe),
    .dio_out  (dio_out),
    .dio_in   (dio_in),
    .irq      (irq),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data)
);

// File: tb/hd3w_spi_engine_tb.sv
`timescale 1ns/1ps
module hd3w_spi_engine_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] wr_cnt = '0;
    logic [CNT_W-1:0] rd_cnt = '0;
    logic             fast_mode = 1'b0;
    logic [31:0]      tx_data = '0;
    logic             tx_valid = 1'b0;
    logic             tx_ready;
    logic [31:0]      rx_data;
    logic             rx_valid;
    logic             rx_ready = 1'b1;
    logic             cs_n, sclk, dio_out, dio_oe, busy, irq;
    logic             dio_in = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] tx_words [4];
    logic [31:0] rx_words [4];

    always #2 clk = ~clk;

    hd3w_spi_engine #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt),
        .fast_mode(fast_mode), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .cs_n(cs_n), .sclk(sclk), .dio_out(dio_out),
        .dio_oe(dio_oe), .dio_in(dio_in), .busy(busy), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One transaction: nw words written, nr words read (last is status).
    task automatic run_txn(input int nw, input int nr, input bit fast, input int ev_delay,
                           input int tx_gap, input int rx_gap, input bit poke);
        int wbits = nw * 32;
        int rbits = nr * 32;
        @(negedge clk);
        start = 1'b1; wr_cnt = CNT_W'(wbits - 1); rd_cnt = CNT_W'(rbits - 1);
        fast_mode = fast; tx_valid = 1'b1; tx_data = tx_words[0];
        #1 chk(cs_n == 1'b1 && busy == 1'b0, "R1", "idle before start", {30'd0, cs_n, busy}, 32'h2);
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < wbits; b++) begin
            logic expb;
            expb = tx_words[b / 32][31 - (b % 32)];
            if (b == 32 && tx_gap > 0) begin
                tx_valid = 1'b0;
                for (int g = 0; g < tx_gap; g++) begin
                    #1 chk(sclk == 1'b0 && tx_ready == 1'b1 && dio_oe == 1'b1 && cs_n == 1'b0,
                           "R9", "tx stall holds clock low", {29'd0, sclk, tx_ready, dio_oe}, 32'h3);
                    @(negedge clk);
                end
                tx_valid = 1'b1;
            end
            tx_data = tx_words[b / 32];
            #1;
            chk(sclk == 1'b0 && dio_oe == 1'b1, "R2", "write low half", {30'd0, sclk, dio_oe}, 32'h1);
            chk(dio_out == expb, "R2", "write bit low half", {31'd0, dio_out}, {31'd0, expb});
            chk(tx_ready == (b % 32 == 0), "R11", "tx_ready timing", {31'd0, tx_ready},
                {31'd0, (b % 32 == 0)});
            @(negedge clk);
            #1;
            chk(sclk == 1'b1 && dio_oe == 1'b1 && dio_out == expb, "R2", "write high half",
                {29'd0, sclk, dio_oe, dio_out}, {29'd0, 1'b1, 1'b1, expb});
            chk(cs_n == 1'b0, "R7", "select during write", {31'd0, cs_n}, 32'h0);
            @(negedge clk);
        end
        #1 chk(sclk == 1'b0 && dio_oe == 1'b0 && cs_n == 1'b0, fast ? "R4" : "R3",
               "turnaround first cycle", {30'd0, sclk, dio_oe}, 32'h0);
        @(negedge clk);
        if (fast) begin
            #1 chk(sclk == 1'b1 && dio_oe == 1'b0, "R4", "turnaround pulse", {30'd0, sclk, dio_oe}, 32'h2);
            @(negedge clk);
        end
        #1 chk(sclk == 1'b0 && dio_oe == 1'b0, fast ? "R4" : "R3", "turnaround last cycle",
               {30'd0, sclk, dio_oe}, 32'h0);
        @(negedge clk);
        for (int b = 0; b < rbits; b++) begin
            dio_in = rx_words[b / 32][31 - (b % 32)];
            #1 chk(sclk == 1'b1 && dio_oe == 1'b0 && cs_n == 1'b0, "R5", "read sample cycle",
                   {29'd0, sclk, dio_oe, cs_n}, 32'h4);
            @(negedge clk);
            dio_in = 1'b0;
            if (b == 31 && rx_gap > 0) begin
                rx_ready = 1'b0;
                for (int g = 0; g < rx_gap; g++) begin
                    #1 chk(sclk == 1'b0 && rx_valid == 1'b1 && rx_data == rx_words[0], "R10",
                           "rx stall holds word", rx_data, rx_words[0]);
                    @(negedge clk);
                end
                rx_ready = 1'b1;
            end
            #1 chk(sclk == 1'b0 && cs_n == 1'b0, "R5", "read low cycle", {30'd0, sclk, cs_n}, 32'h0);
            if (b % 32 == 31)
                chk(rx_valid == 1'b1 && rx_data == rx_words[b / 32], "R5", "received word",
                    rx_data, rx_words[b / 32]);
            @(negedge clk);
        end
        for (int d = 0; d < ev_delay; d++) begin
            if (poke && d == 0) begin start = 1'b1; wr_cnt = CNT_W'(5); end
            #1 chk(busy == 1'b1 && cs_n == 1'b0 && sclk == 1'b0 && irq == 1'b0, "R6",
                   "waiting for event", {28'd0, busy, cs_n, sclk, irq}, 32'h8);
            @(negedge clk);
            start = 1'b0;
        end
        dio_in = 1'b1;
        if (poke && ev_delay == 0) begin start = 1'b1; wr_cnt = CNT_W'(5); end
        #1 chk(irq == 1'b0 && busy == 1'b1, "R6", "no irq before event", {30'd0, irq, busy}, 32'h1);
        @(negedge clk);
        dio_in = 1'b0; start = 1'b0;
        #1 chk(irq == 1'b1 && cs_n == 1'b1 && busy == 1'b0, "R6", "irq on event, idle",
               {29'd0, irq, cs_n, busy}, 32'h6);
        chk(sclk == 1'b0 && dio_oe == 1'b0, "R1", "idle pins after event", {30'd0, sclk, dio_oe}, 32'h0);
        @(negedge clk);
        #1 chk(irq == 1'b0, "R6", "irq single cycle", {31'd0, irq}, 32'h0);
        if (poke)
            chk(busy == 1'b0 && cs_n == 1'b1, "R8", "start during busy ignored", {30'd0, busy, cs_n}, 32'h1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cs_n == 1'b1 && sclk == 1'b0 && dio_oe == 1'b0 && dio_out == 1'b0, "R1", "reset pins",
            {28'd0, cs_n, sclk, dio_oe, dio_out}, 32'h8);
        chk(busy == 1'b0 && irq == 1'b0 && tx_ready == 1'b0 && rx_valid == 1'b0, "R1", "reset status",
            {28'd0, busy, irq, tx_ready, rx_valid}, 32'h0);

        // Command-write: two words, status back, normal turnaround, late event.
        tx_words[0] = 32'hA5C3_0F81; tx_words[1] = 32'h1234_FEDC;
        rx_words[0] = 32'hDEAD_BEEF;
        run_txn(2, 1, 1'b0, 3, 0, 0, 1'b0);

        // Command-read: one command, two data words plus status, fast turnaround,
        // immediate event, start strobes during the run.
        tx_words[0] = 32'h8000_0001;
        rx_words[0] = 32'hCAFE_0123; rx_words[1] = 32'h5555_AAAA; rx_words[2] = 32'h0F0F_F0F1;
        run_txn(1, 3, 1'b1, 0, 0, 0, 1'b1);

        // Both streams stall mid transaction; start poke during event wait.
        tx_words[0] = 32'h7F00_00FE; tx_words[1] = 32'hC001_D00D;
        rx_words[0] = 32'h8421_1248; rx_words[1] = 32'h0000_0001;
        run_txn(2, 2, 1'b0, 2, 3, 2, 1'b1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule